// File: doc/BRIEF.md
# Region-Based Memory Security Filter

This block sits in front of a memory port and decides, one access at a time, whether the access may proceed. Each access carries an address, the index of the filter instance it arrives through, a secure/non-secure flag, a read/write direction and a 4-bit requester ID. The block compares the address against a small table of programmable regions. The highest-numbered region that is enabled for that filter and contains the address decides the outcome. The block then returns allow or fault, together with the index of the deciding region. A faulted access must not be forwarded downstream.

The table is written and read through a plain 32-bit register port. Each region has a 32-byte window starting at 0x100 plus 32×region. The window holds six words: base low (+0x0), base high (+0x4), top low (+0x8), top high (+0xC), attribute (+0x10) and ID access (+0x14). Address 0x000 holds a read-only build word. Four byte-wide identity registers sit at 0xFF0, 0xFF4, 0xFF8 and 0xFFC. Region 0 is fixed: it spans the whole address space and is live on every filter. Only its permission words can be written.

Top module: `memsec_filter`

## Requirements
- R1: After reset, rsp_valid, rsp_allow, rsp_fault and cfg_rdata are 0. Regions 1 and up have no filter enabled. Every region has secure permission 0 and an ID-access word of 0, so every access is faulted by region 0.
- R2: A check presented with chk_valid in one cycle gets rsp_valid, rsp_allow/rsp_fault and rsp_region in the next cycle. With no chk_valid there is no response.
- R3: Region 0 always covers addresses 0 to 2^ADDR_W-1 on every filter. Writes to its base or top words are ignored: base reads back 0, top reads back all ones within ADDR_W. Its filter-enable bits read back as all ones, while its permission field and ID-access word stay writable.
- R4: Writes to the base-low word clear bits 11:0. Writes to the top-low word set bits 11:0. Bits of a high word above ADDR_W-33 are dropped.
- R5: A region other than 0 matches when base ≤ address ≤ top, both bounds inclusive, and its attribute bit [chk_filter] (filter-enable bitmap in bits NUM_FILTERS-1:0) is set.
- R6: When several regions match, the one with the highest index decides and is reported on rsp_region.
- R7: A secure access is judged by attribute bits 31:30: 0 none, 1 read only, 2 write only, 3 read and write.
- R8: A non-secure access with ID n is allowed only if ID-access bit 16+n (read) or bit n (write) of the deciding region is set.
- R9: Address 0x000 reads regions-1 in bits 4:0, ADDR_W-1 in bits 13:8 and filters-1 in bits 25:24.
- R10: Addresses 0xFF0, 0xFF4, 0xFF8 and 0xFFC read the bytes 0x0D, 0xF0, 0x05 and 0xB1, which form 0xB105F00D from least significant upward.
- R11: Every response raises exactly one of rsp_allow and rsp_fault. Both stay low when there is no response.
- R12: cfg_rdata carries the addressed word one cycle after cfg_rd_en and is 0 otherwise. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after cfg_rd_en |
| chk_valid | input | 1 | Access check request |
| chk_addr | input | ADDR_W | Access address |
| chk_filter | input | FILT_W | Filter instance the access arrives through |
| chk_secure | input | 1 | Access is secure |
| chk_write | input | 1 | Access is a write |
| chk_id | input | 4 | Requester ID for non-secure accesses |
| rsp_valid | output | 1 | Check result present |
| rsp_allow | output | 1 | Access may proceed |
| rsp_fault | output | 1 | Access rejected |
| rsp_region | output | RIDX_W | Index of the deciding region |

## Verification
The check response is due one clock edge after the request. The register read data is due one edge after the read strobe. A register write takes effect for a check presented in the cycle that follows it. The bench drives on falling edges and compares at the next falling edge, so each result is sampled half a period after the edge that produced it. A monitor compares rsp_valid against the delayed request on every cycle. Each access result is compared with a behavioural region model kept in the bench.

// File: rtl/memsec_pkg.sv
package memsec_pkg;

    localparam int unsigned CFG_AW = 12;
    localparam logic [31:0] COMPONENT_ID    = 32'hB105_F00D;
    localparam logic [11:0] BUILD_CFG_ADDR  = 12'h000;
    localparam logic [11:0] REGION_WIN_BASE = 12'h100;
    localparam logic [7:0]  CID_PAGE        = 8'hFF;
    localparam int unsigned PERM_LSB        = 30;
    localparam int unsigned ID_RD_LSB       = 16;
    localparam int unsigned ID_W            = 4;

    // word index inside a region window (byte offset >> 2)
    typedef enum logic [2:0] {
        W_BASE_LO = 3'd0,
        W_BASE_HI = 3'd1,
        W_TOP_LO  = 3'd2,
        W_TOP_HI  = 3'd3,
        W_ATTR    = 3'd4,
        W_IDACC   = 3'd5
    } field_e;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_RD   = 2'd1,
        SP_WR   = 2'd2,
        SP_RDWR = 2'd3
    } sec_perm_e;

    typedef struct packed {
        logic            secure;
        logic            write;
        logic [ID_W-1:0] id;
    } acc_attr_t;

    function automatic logic perm_allows(sec_perm_e p, logic wr);
        return wr ? p[1] : p[0];
    endfunction

    function automatic logic [7:0] cid_byte(logic [1:0] idx);
        return COMPONENT_ID[{idx, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/memsec_regs.sv
module memsec_regs
    import memsec_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 9,
    parameter int unsigned NUM_FILTERS = 4,
    parameter int unsigned ADDR_W      = 40,
    localparam int unsigned RIDX_W     = $clog2(NUM_REGIONS)
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cfg_wr_en,
    input  logic                                 cfg_rd_en,
    input  logic [CFG_AW-1:0]                    cfg_addr,
    input  logic [31:0]                          cfg_wdata,
    output logic [31:0]                          cfg_rdata,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]   region_base,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]   region_top,
    output logic [NUM_REGIONS-1:0][NUM_FILTERS-1:0] region_fen,
    output logic [NUM_REGIONS-1:0][1:0]          region_perm,
    output logic [NUM_REGIONS-1:0][31:0]         region_idacc
);

    localparam logic [31:0] BUILD_WORD = 32'(NUM_REGIONS - 1)
                                       | (32'(ADDR_W - 1) << 8)
                                       | (32'(NUM_FILTERS - 1) << 24);

    logic [CFG_AW-1:0] rel;
    logic              win_hit;
    logic [RIDX_W-1:0] ridx;
    field_e            word;

    assign rel     = cfg_addr - REGION_WIN_BASE;
    assign word    = field_e'(rel[4:2]);
    assign ridx    = rel[5 +: RIDX_W];
    assign win_hit = (cfg_addr >= REGION_WIN_BASE)
                  && (rel[11:5] < 7'(NUM_REGIONS))
                  && (rel[4:2] <= 3'd5)
                  && (rel[1:0] == 2'b00);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic      sel;
        sec_perm_e perm_q;
        logic [31:0] idacc_q;

        assign sel = cfg_wr_en && win_hit && (ridx == RIDX_W'(r));

        always_ff @(posedge clk) begin
            if (rst) begin
                perm_q  <= SP_NONE;
                idacc_q <= '0;
            end else if (sel) begin
                if (word == W_ATTR)  perm_q  <= sec_perm_e'(cfg_wdata[PERM_LSB +: 2]);
                if (word == W_IDACC) idacc_q <= cfg_wdata;
            end
        end

        assign region_perm[r]  = perm_q;
        assign region_idacc[r] = idacc_q;

        if (r == 0) begin : g_fixed
            assign region_base[r] = '0;
            assign region_top[r]  = '1;
            assign region_fen[r]  = '1;
        end else begin : g_prog
            logic [ADDR_W-1:0]      base_q, top_q;
            logic [NUM_FILTERS-1:0] fen_q;
            logic [63:0]            base_w, top_w;

            assign base_w = 64'(base_q);
            assign top_w  = 64'(top_q);

            always_ff @(posedge clk) begin
                if (rst) begin
                    base_q <= '0;
                    top_q  <= ADDR_W'(12'hFFF);
                    fen_q  <= '0;
                end else if (sel) begin
                    case (word)
                        W_BASE_LO: base_q <= ADDR_W'({base_w[63:32], cfg_wdata[31:12], 12'h000});
                        W_BASE_HI: base_q <= ADDR_W'({cfg_wdata, base_w[31:0]});
                        W_TOP_LO:  top_q  <= ADDR_W'({top_w[63:32], cfg_wdata[31:12], 12'hFFF});
                        W_TOP_HI:  top_q  <= ADDR_W'({cfg_wdata, top_w[31:0]});
                        W_ATTR:    fen_q  <= cfg_wdata[NUM_FILTERS-1:0];
                        default:   ;
                    endcase
                end
            end

            assign region_base[r] = base_q;
            assign region_top[r]  = top_q;
            assign region_fen[r]  = fen_q;
        end
    end

    logic [31:0] rd_val;
    logic [63:0] b64, t64;

    assign b64 = 64'(region_base[ridx]);
    assign t64 = 64'(region_top[ridx]);

    always_comb begin
        rd_val = '0;
        if (cfg_addr == BUILD_CFG_ADDR) begin
            rd_val = BUILD_WORD;
        end else if (cfg_addr[11:4] == CID_PAGE && cfg_addr[1:0] == 2'b00) begin
            rd_val = {24'h0, cid_byte(cfg_addr[3:2])};
        end else if (win_hit) begin
            case (word)
                W_BASE_LO: rd_val = b64[31:0];
                W_BASE_HI: rd_val = b64[63:32];
                W_TOP_LO:  rd_val = t64[31:0];
                W_TOP_HI:  rd_val = t64[63:32];
                W_ATTR:    rd_val = 32'(region_fen[ridx]) | {region_perm[ridx], 30'b0};
                W_IDACC:   rd_val = region_idacc[ridx];
                default:   rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_rdata <= '0;
        else     cfg_rdata <= cfg_rd_en ? rd_val : '0;
    end

endmodule

// File: rtl/memsec_region_match.sv
module memsec_region_match #(
    parameter int unsigned ADDR_W      = 40,
    parameter int unsigned NUM_FILTERS = 4,
    parameter int unsigned FILT_W      = 2
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [FILT_W-1:0]      filter,
    input  logic [ADDR_W-1:0]      base,
    input  logic [ADDR_W-1:0]      top,
    input  logic [NUM_FILTERS-1:0] fen,
    output logic                   hit
);

    logic fen_sel;

    always_comb begin
        fen_sel = 1'b0;
        for (int f = 0; f < NUM_FILTERS; f++)
            if (filter == FILT_W'(f)) fen_sel = fen[f];
    end

    assign hit = fen_sel && (addr >= base) && (addr <= top);

endmodule

// File: rtl/memsec_arbiter.sv
module memsec_arbiter
    import memsec_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 9,
    localparam int unsigned RIDX_W     = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0]       hit,
    input  logic [NUM_REGIONS-1:0][1:0]  perm,
    input  logic [NUM_REGIONS-1:0][31:0] idacc,
    input  acc_attr_t                    acc,
    output logic [RIDX_W-1:0]            win,
    output logic                         allow
);

    sec_perm_e   wperm;
    logic [31:0] widacc;

    always_comb begin
        win = '0;
        for (int r = 0; r < NUM_REGIONS; r++)
            if (hit[r]) win = RIDX_W'(r);
    end

    assign wperm  = sec_perm_e'(perm[win]);
    assign widacc = idacc[win];
    assign allow  = acc.secure ? perm_allows(wperm, acc.write)
                               : widacc[{~acc.write, acc.id}];

endmodule

// File: rtl/memsec_filter.sv
module memsec_filter
    import memsec_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 9,
    parameter int unsigned NUM_FILTERS = 4,
    parameter int unsigned ADDR_W      = 40,
    localparam int unsigned RIDX_W     = $clog2(NUM_REGIONS),
    localparam int unsigned FILT_W     = (NUM_FILTERS > 1) ? $clog2(NUM_FILTERS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              chk_valid,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [FILT_W-1:0] chk_filter,
    input  logic              chk_secure,
    input  logic              chk_write,
    input  logic [3:0]        chk_id,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_fault,
    output logic [RIDX_W-1:0] rsp_region
);

    logic [NUM_REGIONS-1:0][ADDR_W-1:0]      region_base, region_top;
    logic [NUM_REGIONS-1:0][NUM_FILTERS-1:0] region_fen;
    logic [NUM_REGIONS-1:0][1:0]             region_perm;
    logic [NUM_REGIONS-1:0][31:0]            region_idacc;
    logic [NUM_REGIONS-1:0]                  hit;
    logic [RIDX_W-1:0]                       win;
    logic                                    allow;
    acc_attr_t                               acc;

    memsec_regs #(
        .NUM_REGIONS(NUM_REGIONS),
        .NUM_FILTERS(NUM_FILTERS),
        .ADDR_W     (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_rd_en   (cfg_rd_en),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .region_base (region_base),
        .region_top  (region_top),
        .region_fen  (region_fen),
        .region_perm (region_perm),
        .region_idacc(region_idacc)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_match
        memsec_region_match #(
            .ADDR_W     (ADDR_W),
            .NUM_FILTERS(NUM_FILTERS),
            .FILT_W     (FILT_W)
        ) u_match (
            .addr  (chk_addr),
            .filter(chk_filter),
            .base  (region_base[r]),
            .top   (region_top[r]),
            .fen   (region_fen[r]),
            .hit   (hit[r])
        );
    end

    assign acc = '{secure: chk_secure, write: chk_write, id: chk_id};

    memsec_arbiter #(
        .NUM_REGIONS(NUM_REGIONS)
    ) u_arb (
        .hit  (hit),
        .perm (region_perm),
        .idacc(region_idacc),
        .acc  (acc),
        .win  (win),
        .allow(allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_allow  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_region <= '0;
        end else begin
            rsp_valid  <= chk_valid;
            rsp_allow  <= chk_valid && allow;
            rsp_fault  <= chk_valid && !allow;
            rsp_region <= chk_valid ? win : '0;
        end
    end

endmodule

// File: rtl/memsec_filter_chk.sv
module memsec_filter_chk #(
    parameter int unsigned NUM_REGIONS = 9,
    parameter int unsigned RIDX_W      = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_rd_en,
    input logic [11:0]       cfg_addr,
    input logic [31:0]       cfg_rdata,
    input logic              chk_valid,
    input logic              rsp_valid,
    input logic              rsp_allow,
    input logic              rsp_fault,
    input logic [RIDX_W-1:0] rsp_region
);

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !rsp_valid);

    // R11
    allow_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_allow != rsp_fault));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_allow && !rsp_fault));

    // R6
    region_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (32'(rsp_region) < NUM_REGIONS));

    // R12
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd_en |=> (cfg_rdata == 32'h0));

    // R3
    region0_base_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_en && cfg_addr == 12'h100) |=> (cfg_rdata == 32'h0));

endmodule

bind memsec_filter memsec_filter_chk #(
    .NUM_REGIONS(NUM_REGIONS),
    .RIDX_W     (RIDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rd_en (cfg_rd_en),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .chk_valid (chk_valid),
    .rsp_valid (rsp_valid),
    .rsp_allow (rsp_allow),
    .rsp_fault (rsp_fault),
    .rsp_region(rsp_region)
);

// File: tb/memsec_filter_test.sv
module memsec_filter_test;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 9;
    localparam int NFLT = 4;
    localparam int AW   = 40;
    localparam logic [63:0] AMASK = (64'h1 << AW) - 64'h1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        chk_valid = 1'b0;
    logic [AW-1:0] chk_addr = '0;
    logic [1:0]  chk_filter = '0;
    logic        chk_secure = 1'b0, chk_write = 1'b0;
    logic [3:0]  chk_id = '0;
    logic        rsp_valid, rsp_allow, rsp_fault;
    logic [3:0]  rsp_region;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    memsec_filter #(.NUM_REGIONS(NREG), .NUM_FILTERS(NFLT), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_filter(chk_filter),
        .chk_secure(chk_secure), .chk_write(chk_write), .chk_id(chk_id),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
        .rsp_region(rsp_region)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural region table
    logic [63:0] m_base [NREG];
    logic [63:0] m_top  [NREG];
    logic [31:0] m_attr [NREG];
    logic [31:0] m_id   [NREG];

    task automatic model_reset();
        for (int r = 0; r < NREG; r++) begin
            m_base[r] = (r == 0) ? 64'h0 : 64'h0;
            m_top[r]  = (r == 0) ? AMASK : 64'hFFF;
            m_attr[r] = 32'h0;
            m_id[r]   = 32'h0;
        end
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int r;
        int w;
        if (a < 12'h100 || a[1:0] != 0) return;
        r = int'((a - 12'h100) >> 5);
        w = int'(((a - 12'h100) >> 2) & 12'h7);
        if (r >= NREG || w > 5) return;
        if (r == 0 && w < 4) return;
        case (w)
            0: m_base[r] = {m_base[r][63:32], d[31:12], 12'h000} & AMASK;
            1: m_base[r] = {d, m_base[r][31:0]} & AMASK;
            2: m_top[r]  = {m_top[r][63:32], d[31:12], 12'hFFF} & AMASK;
            3: m_top[r]  = {d, m_top[r][31:0]} & AMASK;
            4: m_attr[r] = d & 32'hC000_000F;
            default: m_id[r] = d;
        endcase
    endtask

    task automatic model_eval(input logic [63:0] a, input int f, input bit sec,
                              input bit wr, input int id, output int win, output bit ok);
        logic [1:0] p;
        win = 0;
        for (int r = 1; r < NREG; r++)
            if (m_attr[r][f] && a >= m_base[r] && a <= m_top[r]) win = r;
        p = m_attr[win][31:30];
        if (sec) ok = wr ? p[1] : p[0];
        else     ok = m_id[win][wr ? id : 16 + id];
    endtask

    task automatic note(input bit pass, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!pass) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic cfg_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        note(cfg_rdata == exp, tag, "cfg_rdata", 64'(cfg_rdata), 64'(exp));
    endtask

    // drive one access, compare with the model, optionally with literal values
    task automatic access(input logic [63:0] a, input int f, input bit sec, input bit wr,
                          input int id, input string tag,
                          input bit lit = 0, input int lit_reg = 0, input bit lit_ok = 0);
        int  win;
        bit  ok;
        model_eval(a & AMASK, f, sec, wr, id, win, ok);
        if (lit) begin
            note(win == lit_reg && ok == lit_ok, tag, "model vs intent",
                 64'({win, 4'(ok)}), 64'({lit_reg, 4'(lit_ok)}));
        end
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = AW'(a); chk_filter = 2'(f);
        chk_secure = sec; chk_write = wr; chk_id = 4'(id);
        @(negedge clk);
        chk_valid = 1'b0;
        note(rsp_valid && rsp_allow == ok && rsp_fault == !ok && int'(rsp_region) == win,
             tag, "response {region,allow,fault}",
             64'({rsp_region, 3'b0, rsp_valid, 3'b0, rsp_allow, 3'b0, rsp_fault}),
             64'({4'(win), 4'h1, 3'b0, ok, 3'b0, !ok}));
    endtask

    // per-clock monitor: R2 response presence tracks the previous request
    logic prev_chk = 1'b0;
    always @(posedge clk) prev_chk <= rst ? 1'b0 : chk_valid;
    always @(negedge clk) begin
        if (!rst && !done)
            note(rsp_valid == prev_chk, "R2", "rsp_valid per clock",
                 64'(rsp_valid), 64'(prev_chk));
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        note(!rsp_valid && !rsp_allow && !rsp_fault && cfg_rdata == 0, "R1",
             "outputs after reset", 64'({rsp_valid, rsp_allow, rsp_fault}), 64'h0);
        cfg_read(12'h130, 32'h0, "R1");
        cfg_read(12'h110, 32'h0000_000F, "R3");
        access(64'h1000, 0, 1, 0, 0, "R1", 1, 0, 0);

        // R9 / R10 / R12
        cfg_read(12'h000, 32'h0300_2708, "R9");
        cfg_read(12'hFF0, 32'h0D, "R10");
        cfg_read(12'hFF4, 32'hF0, "R10");
        cfg_read(12'hFF8, 32'h05, "R10");
        cfg_read(12'hFFC, 32'hB1, "R10");
        cfg_read(12'h080, 32'h0, "R12");
        cfg_read(12'h220, 32'h0, "R12");

        // R3 region 0 fixed span, permissions writable
        cfg_write(12'h110, 32'h4000_0000);
        cfg_read(12'h110, 32'h4000_000F, "R3");
        cfg_write(12'h100, 32'h0000_5000);
        cfg_write(12'h108, 32'h0000_0000);
        cfg_read(12'h100, 32'h0, "R3");
        cfg_read(12'h108, 32'hFFFF_FFFF, "R3");
        cfg_read(12'h10C, 32'h0000_00FF, "R3");
        access(64'h0, 3, 1, 0, 0, "R7", 1, 0, 1);
        access(64'hFF_FFFF_FFFF, 2, 1, 1, 0, "R7", 1, 0, 0);

        // R4 alignment and masking, region 2
        cfg_write(12'h140, 32'h0001_0ABC);
        cfg_write(12'h148, 32'h0001_F000);
        cfg_read(12'h140, 32'h0001_0000, "R4");
        cfg_read(12'h148, 32'h0001_FFFF, "R4");
        cfg_write(12'h14C, 32'hFFFF_FF00);
        cfg_read(12'h14C, 32'h0000_0000, "R4");
        cfg_write(12'h150, 32'hC000_0002);
        cfg_write(12'h154, 32'h0008_0000);

        // R5 bounds and filter enable
        access(64'h1_0000, 1, 1, 1, 0, "R5", 1, 2, 1);
        access(64'h1_FFFF, 1, 1, 0, 0, "R5", 1, 2, 1);
        access(64'h2_0000, 1, 1, 1, 0, "R5", 1, 0, 0);
        access(64'h0_FFFF, 1, 1, 0, 0, "R5", 1, 0, 1);
        access(64'h1_8000, 0, 1, 1, 0, "R5", 1, 0, 0);

        // R8 non-secure ID access
        access(64'h1_2000, 1, 0, 0, 3, "R8", 1, 2, 1);
        access(64'h1_2000, 1, 0, 1, 3, "R8", 1, 2, 0);
        access(64'h1_2000, 1, 0, 0, 4, "R8", 1, 2, 0);

        // R6 overlap priority, region 5 write only
        cfg_write(12'h1A0, 32'h0001_8000);
        cfg_write(12'h1A8, 32'h0001_8FFF);
        cfg_write(12'h1B0, 32'h8000_0002);
        access(64'h1_8800, 1, 1, 0, 0, "R6", 1, 5, 0);
        access(64'h1_8800, 1, 1, 1, 0, "R6", 1, 5, 1);
        access(64'h1_9000, 1, 1, 0, 0, "R6", 1, 2, 1);

        // R5 high word, region 8
        cfg_write(12'h200, 32'h0);
        cfg_write(12'h204, 32'h3);
        cfg_write(12'h208, 32'h0);
        cfg_write(12'h20C, 32'h3);
        cfg_write(12'h210, 32'h4000_000F);
        cfg_read(12'h20C, 32'h3, "R4");
        access(64'h3_0000_0800, 2, 1, 0, 0, "R5", 1, 8, 1);
        access(64'h0_0000_0800, 2, 1, 0, 0, "R5", 1, 0, 1);
        access(64'h3_0000_1000, 2, 1, 0, 0, "R5", 1, 0, 1);

        // region 3 with mixed non-secure masks for the sweep
        cfg_write(12'h160, 32'h0000_4000);
        cfg_write(12'h168, 32'h0000_BFFF);
        cfg_write(12'h170, 32'h4000_0005);
        cfg_write(12'h174, 32'h00F0_0F0F);
        cfg_write(12'h114, 32'h5555_AAAA);

        // model-driven sweep: R5 R6 R7 R8
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            int k;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            k = int'(lfsr[7:4]) % NREG;
            case (int'(lfsr[10:8]) % 6)
                0: a = m_base[k];
                1: a = m_top[k];
                2: a = m_top[k] + 64'h1;
                3: a = m_base[k] - 64'h1;
                4: a = 64'(lfsr[31:12]);
                default: a = 64'h3_0000_0000 | 64'(lfsr[31:20]);
            endcase
            access(a & AMASK, int'(lfsr[12:11]), lfsr[13], lfsr[14], int'(lfsr[18:15]), "R8");
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule